// File: doc/BRIEF.md
# Receive MAC Statistics Counter Bank

This block sits next to an Ethernet receive MAC. Each time a frame finishes, the MAC presents a status summary for one cycle. The summary holds the frame length including the 4-byte FCS, an FCS-bad flag, broadcast and multicast flags, pause and other-control indications, a length-field mismatch, an alignment error, and three drop causes: receive FIFO overflow, return-descriptor overflow and address filtering. From this summary the block updates a bank of saturating counters. In one cycle a single summary can update several counters.

Software reads any counter through a simple indexed read port. The value appears one cycle after the request, and reading a counter clears it. Software therefore adds up the totals itself. If a read and a frame update hit the same counter in the same cycle, the read returns the old value and the counter restarts at this frame's increment, so no event is lost. The highest frame length that still counts as in-size is set on the `cfg_mtu` input.

Top module: `rxmac_stat_bank`

## Requirements
- R1: A good frame increments exactly one size bin, chosen by its length L including FCS: L=64 goes to index 10, 65..127 to index 11, 128..255 to index 12, 256..511 to index 13, 512..1023 to index 14, 1024..1518 to index 15, and 1519..cfg_mtu to index 16. A frame is good when L>=64, L<=cfg_mtu, the FCS is fine, and it has no length error, alignment error or drop.
- R2: Any frame with L<64 increments the runt counter (index 8) if its FCS is fine, or the fragment counter (index 9) if its FCS is bad. It never increments both.
- R3: A good frame adds L-4 to the good-byte counter (index 7). A good broadcast frame also adds L-4 to index 21. A good multicast frame also adds L-4 to index 22.
- R4: A frame with a fine FCS and the pause flag increments index 3. A frame with a fine FCS, the control flag and no pause flag increments index 4. A pause frame never increments index 4.
- R5: Any frame with L>cfg_mtu increments the oversize counter (index 17) and is not good.
- R6: FIFO-overflow, descriptor-overflow and address-filter drops increment indices 18, 19 and 23 respectively. A dropped frame is not good.
- R7: Counter index map: 0 good frames, 1 good broadcast, 2 good multicast, 3 pause, 4 control, 5 FCS error with L>=64, 6 length mismatch, 7 good bytes, 8 runt, 9 fragment, 10..16 size bins, 17 oversize, 18 FIFO drop, 19 descriptor drop, 20 alignment error, 21 broadcast bytes, 22 multicast bytes, 23 filter drop. When rd_en is high at a clock edge, the next cycle shows rd_valid high and rd_data equal to the counter's value before that edge.
- R8: A read clears the counter it selects.
- R9: When a read and a frame update hit the same counter in one cycle, the read returns the old value and the counter then holds only this frame's increment.
- R10: Counters saturate at all ones and never wrap.
- R11: One summary updates every counter it qualifies for in the same cycle. For example, a good broadcast frame updates indices 0, 1, 7, 21 and one size bin.
- R12: An FCS-bad frame with L>=64 increments index 5. A length mismatch increments index 6. An alignment error increments index 20. None of these frames is good.
- R13: A read of an index from 24 upward returns zero.
- R14: After reset every counter is zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Frame status summary present this cycle |
| st_len | input | LEN_W | Frame length including FCS |
| st_fcs_bad | input | 1 | FCS check failed |
| st_bcast | input | 1 | Broadcast destination |
| st_mcast | input | 1 | Multicast destination |
| st_pause | input | 1 | Pause frame |
| st_ctrl | input | 1 | MAC control frame |
| st_len_err | input | 1 | Length field disagrees with size |
| st_align_err | input | 1 | Alignment error |
| st_fifo_drop | input | 1 | Dropped: receive FIFO overflow |
| st_desc_drop | input | 1 | Dropped: return-descriptor overflow |
| st_filt_drop | input | 1 | Dropped: address filter |
| cfg_mtu | input | LEN_W | Largest in-size frame length |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Counter index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value read |

## Verification
The bench builds the bank with CNT_W=12 and LEN_W=14. With this narrow width, the byte counters hit saturation during a single length sweep, and a run of about 4100 back-to-back frames saturates the good-frame counter well inside the cycle budget. With cfg_mtu=1536, every length from 0 to 1600 falls into a reachable class, including the 1519..MTU bin and the oversize class. The flag sweep also drives all 1024 combinations of the ten status flags at lengths on each side of the 64-byte and MTU boundaries.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NUM_CNT = 24;
  localparam int IDX_W   = 5;

  localparam int C_OK     = 0;
  localparam int C_BC     = 1;
  localparam int C_MC     = 2;
  localparam int C_PAUSE  = 3;
  localparam int C_CTRL   = 4;
  localparam int C_FCS    = 5;
  localparam int C_LENERR = 6;
  localparam int C_BYTES  = 7;
  localparam int C_RUNT   = 8;
  localparam int C_FRAG   = 9;
  localparam int C_BIN0   = 10;
  localparam int C_BINMAX = 16;
  localparam int C_OVS    = 17;
  localparam int C_FIFO   = 18;
  localparam int C_DESC   = 19;
  localparam int C_ALIGN  = 20;
  localparam int C_BCB    = 21;
  localparam int C_MCB    = 22;
  localparam int C_FILT   = 23;

  typedef struct packed {
    logic fcs_bad;
    logic bcast;
    logic mcast;
    logic pause;
    logic ctrl;
    logic len_err;
    logic align_err;
    logic fifo_drop;
    logic desc_drop;
    logic filt_drop;
  } frm_flags_t;
endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic                             valid,
  input  logic [LEN_W-1:0]                 len,
  input  logic [LEN_W-1:0]                 mtu,
  input  frm_flags_t                       fl,
  output logic [NUM_CNT-1:0][LEN_W-1:0]    inc
);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0] FCS_B = LEN_W'(4);
  localparam logic [LEN_W-1:0] MINF  = LEN_W'(64);

  // one-hot size bin for a frame already known to be at least 64 bytes
  function automatic logic [6:0] size_bin(input logic [LEN_W-1:0] l);
    logic [6:0] b;
    b = '0;
    if (l == LEN_W'(64))         b[0] = 1'b1;
    else if (l <= LEN_W'(127))   b[1] = 1'b1;
    else if (l <= LEN_W'(255))   b[2] = 1'b1;
    else if (l <= LEN_W'(511))   b[3] = 1'b1;
    else if (l <= LEN_W'(1023))  b[4] = 1'b1;
    else if (l <= LEN_W'(1518))  b[5] = 1'b1;
    else                         b[6] = 1'b1;
    return b;
  endfunction

  function automatic logic [LEN_W-1:0] payload_bytes(input logic [LEN_W-1:0] l);
    return l - FCS_B;
  endfunction

  logic       short_f, over_f, dropped, good;
  logic [6:0] bin;

  always_comb begin
    short_f = len < MINF;
    over_f  = len > mtu;
    dropped = fl.fifo_drop | fl.desc_drop | fl.filt_drop;
    good    = valid & ~short_f & ~over_f & ~fl.fcs_bad & ~dropped &
              ~fl.len_err & ~fl.align_err;
    bin     = size_bin(len);

    inc = '0;
    if (valid) begin
      if (short_f &  fl.fcs_bad)  inc[C_FRAG]   = ONE;
      if (short_f & ~fl.fcs_bad)  inc[C_RUNT]   = ONE;
      if (~short_f & fl.fcs_bad)  inc[C_FCS]    = ONE;
      if (over_f)                 inc[C_OVS]    = ONE;
      if (fl.len_err)             inc[C_LENERR] = ONE;
      if (fl.align_err)           inc[C_ALIGN]  = ONE;
      if (fl.fifo_drop)           inc[C_FIFO]   = ONE;
      if (fl.desc_drop)           inc[C_DESC]   = ONE;
      if (fl.filt_drop)           inc[C_FILT]   = ONE;
      if (~fl.fcs_bad & fl.pause) inc[C_PAUSE]  = ONE;
      if (~fl.fcs_bad & ~fl.pause & fl.ctrl) inc[C_CTRL] = ONE;
    end
    if (good) begin
      inc[C_OK]    = ONE;
      inc[C_BYTES] = payload_bytes(len);
      if (fl.bcast) begin
        inc[C_BC]  = ONE;
        inc[C_BCB] = payload_bytes(len);
      end
      if (fl.mcast) begin
        inc[C_MC]  = ONE;
        inc[C_MCB] = payload_bytes(len);
      end
      for (int b = 0; b < 7; b++)
        if (bin[b]) inc[C_BIN0 + b] = ONE;
    end
  end
endmodule

// File: rtl/rxstat_cell.sv
module rxstat_cell #(
  parameter int CNT_W = 64,
  parameter int INC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    if (s[SUM_W-1:CNT_W] != '0) return {CNT_W{1'b1}};
    return s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] base;
  assign base = clr ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sat_add(base, inc);
  end
endmodule

// File: rtl/rxstat_rdport.sv
module rxstat_rdport
  import rxstat_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
  output logic [NUM_CNT-1:0]              clr,
  output logic                            rd_valid,
  output logic [CNT_W-1:0]                rd_data
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_dec
    assign clr[k] = rd_en && (rd_idx == IDX_W'(k));
  end

  logic in_range;
  assign in_range = int'(rd_idx) < NUM_CNT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= in_range ? cnt[rd_idx] : '0;
    end
  end
endmodule

// File: rtl/rxmac_stat_bank.sv
module rxmac_stat_bank
  import rxstat_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [LEN_W-1:0] st_len,
  input  logic             st_fcs_bad,
  input  logic             st_bcast,
  input  logic             st_mcast,
  input  logic             st_pause,
  input  logic             st_ctrl,
  input  logic             st_len_err,
  input  logic             st_align_err,
  input  logic             st_fifo_drop,
  input  logic             st_desc_drop,
  input  logic             st_filt_drop,
  input  logic [LEN_W-1:0] cfg_mtu,
  input  logic             rd_en,
  input  logic [4:0]       rd_idx,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  frm_flags_t                      flags;
  logic [NUM_CNT-1:0][LEN_W-1:0]   inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;
  logic [NUM_CNT-1:0]              clr;
  logic [NUM_CNT-1:0]              hit;     // counter receives an increment
  logic [CNT_W-1:0]                rd_peek; // value a read this cycle returns

  assign flags = '{fcs_bad: st_fcs_bad, bcast: st_bcast, mcast: st_mcast,
                   pause: st_pause, ctrl: st_ctrl, len_err: st_len_err,
                   align_err: st_align_err, fifo_drop: st_fifo_drop,
                   desc_drop: st_desc_drop, filt_drop: st_filt_drop};

  rxstat_classify #(.LEN_W(LEN_W)) u_cls (
    .valid (st_valid),
    .len   (st_len),
    .mtu   (cfg_mtu),
    .fl    (flags),
    .inc   (inc)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign hit[k] = inc[k] != '0;
    rxstat_cell #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr[k]),
      .inc   (inc[k]),
      .cnt   (cnt_q[k])
    );
  end

  assign rd_peek = (int'(rd_idx) < NUM_CNT) ? cnt_q[rd_idx] : '0;

  rxstat_rdport #(.CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .cnt      (cnt_q),
    .clr      (clr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/rxmac_stat_bank_chk.sv
module rxmac_stat_bank_chk
  import rxstat_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rd_en,
  input logic                           rd_valid,
  input logic [CNT_W-1:0]               rd_data,
  input logic [CNT_W-1:0]               rd_peek,
  input logic [NUM_CNT-1:0]             hit,
  input logic [NUM_CNT-1:0]             clr,
  input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q
);
  p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_rd_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == $past(rd_peek));
  p_one_bin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[C_BINMAX:C_BIN0]));
  p_runt_frag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit[C_RUNT] && hit[C_FRAG]));
  p_pause_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit[C_PAUSE] && hit[C_CTRL]));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_k
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !hit[k]) |=> cnt_q[k] == '0);
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && hit[k]) |=> cnt_q[k] != '0);
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr[k] |=> cnt_q[k] >= $past(cnt_q[k]));
  end
endmodule

bind rxmac_stat_bank rxmac_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_peek  (rd_peek),
  .hit      (hit),
  .clr      (clr),
  .cnt_q    (cnt_q)
);

// File: tb/rxmac_stat_bank_tb.sv
module rxmac_stat_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int LW = 14;
  localparam longint MAXV = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_fcs_bad = 0, st_bcast = 0, st_mcast = 0, st_pause = 0;
  logic st_ctrl = 0, st_len_err = 0, st_align_err = 0;
  logic st_fifo_drop = 0, st_desc_drop = 0, st_filt_drop = 0;
  logic [LW-1:0] st_len = '0, cfg_mtu = LW'(1536);
  logic rd_en = 0;
  logic [4:0] rd_idx = '0;
  logic rd_valid;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  longint exp_c [0:31];
  int mtu_i = 1536;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxmac_stat_bank #(.CNT_W(CW), .LEN_W(LW)) u_dut (.*);

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void bump(input int k, input longint amt);
    exp_c[k] = (exp_c[k] + amt > MAXV) ? MAXV : exp_c[k] + amt;
  endfunction

  // bench model of classification; bits of f: 0 fcs,1 bc,2 mc,3 pause,
  // 4 ctrl,5 len_err,6 align,7 fifo,8 desc,9 filter
  function automatic void model(input int len, input logic [9:0] f);
    int thr [6] = '{64, 127, 255, 511, 1023, 1518};
    int b;
    logic good;
    if (f[7]) bump(18, 1);
    if (f[8]) bump(19, 1);
    if (f[9]) bump(23, 1);
    if (f[5]) bump(6, 1);
    if (f[6]) bump(20, 1);
    if (len < 64) bump(f[0] ? 9 : 8, 1);
    else if (f[0]) bump(5, 1);
    if (len > mtu_i) bump(17, 1);
    if (!f[0] && f[3]) bump(3, 1);
    else if (!f[0] && f[4]) bump(4, 1);
    good = (f & 10'b11_1110_0001) == 0 && len >= 64 && len <= mtu_i;
    if (good) begin
      bump(0, 1);
      bump(7, len - 4);
      if (f[1]) begin bump(1, 1); bump(21, len - 4); end
      if (f[2]) begin bump(2, 1); bump(22, len - 4); end
      b = 16;
      for (int i = 5; i >= 0; i--) if (len <= thr[i]) b = 10 + i;
      bump(b, 1);
    end
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic put(input int len, input logic [9:0] f, input logic rd,
                     input int idx, input string req);
    longint old;
    st_valid = 1; st_len = LW'(len);
    {st_filt_drop, st_desc_drop, st_fifo_drop, st_align_err, st_len_err,
     st_ctrl, st_pause, st_mcast, st_bcast, st_fcs_bad} = f;
    rd_en = rd; rd_idx = 5'(idx);
    old = exp_c[idx];
    if (rd) exp_c[idx] = 0;
    model(len, f);
    @(negedge clk);
    st_valid = 0; rd_en = 0;
    if (rd) begin
      chk(req, rd_data, old);
      chk(req, rd_valid, 1);
    end
  endtask

  task automatic rd_one(input int idx, input string req);
    rd_en = 1; rd_idx = 5'(idx);
    @(negedge clk);
    rd_en = 0;
    chk(req, rd_valid, 1);
    chk($sformatf("%s idx %0d", req, idx), rd_data, exp_c[idx]);
    exp_c[idx] = 0;
  endtask

  task automatic rd_all(input string req);
    for (int k = 0; k < 32; k++) rd_one(k, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) exp_c[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R14: reset state
    chk("R14 rd_valid", rd_valid, 0);
    rd_all("R14/R13");

    // R1 R2 R3 R5 R10: exhaustive length sweep, byte counters saturate
    for (int l = 0; l <= 1600; l++) put(l, 10'd0, 0, 0, "");
    rd_all("R1/R2/R3/R5/R10");
    // R8: everything cleared by the reads
    rd_all("R8");

    // R3 exact byte sums, R11 several counters at once
    put(100, 10'b00_0000_0010, 0, 0, "");
    put(200, 10'b00_0000_0100, 0, 0, "");
    put(64,  10'b00_0000_0110, 0, 0, "");
    rd_all("R3/R11");

    // R2 R4 R5 R6 R12: all flag combinations at boundary lengths
    foreach (exp_c[i]) if (exp_c[i] != 0) chk("R8 model", exp_c[i], 0);
    for (int f = 0; f < 1024; f++) begin
      put(63, 10'(f), 0, 0, "");
      put(64, 10'(f), 0, 0, "");
      put(127, 10'(f), 0, 0, "");
      put(1536, 10'(f), 0, 0, "");
      put(1537, 10'(f), 0, 0, "");
    end
    rd_all("R2/R4/R5/R6/R12");

    // R5 with a smaller MTU
    cfg_mtu = LW'(1000); mtu_i = 1000;
    put(1000, 10'd0, 0, 0, "");
    put(1001, 10'd0, 0, 0, "");
    put(1519, 10'd0, 0, 0, "");
    rd_all("R5 mtu1000");
    cfg_mtu = LW'(1536); mtu_i = 1536;

    // R9: read and update of the same counter in one cycle
    put(100, 10'd0, 0, 0, "");
    put(100, 10'd0, 0, 0, "");
    put(100, 10'd0, 0, 0, "");
    put(200, 10'd0, 1, 0, "R9 ok old");
    put(300, 10'd0, 1, 7, "R9 bytes old");
    rd_all("R9 reload");

    // R13: out-of-range indices while counters are non-zero
    put(80, 10'd0, 0, 0, "");
    for (int k = 24; k < 32; k++) rd_one(k, "R13");
    rd_all("R13 rest");

    // R10: event counter saturation
    for (int n = 0; n < 4100; n++) put(64, 10'd0, 0, 0, "");
    rd_one(0, "R10 ok sat");
    rd_one(10, "R10 bin sat");
    rd_all("R10 rest");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule